// File: doc/BRIEF.md
# Dual-Organization DRAM Command Decoder

This block is the device-side command front end of an eight-bank graphics DRAM that can be strapped into one of two organizations. On every rising clock edge it samples the chip selects, the three command strobes, a bank address, a row/column address and an option bit. It decodes activate, read, write, precharge and refresh. It keeps, for every bank, a small state machine that records whether the bank is closed, open, or open with a self-timed close pending, together with the open row. Each legal command yields a registered core-access strobe that carries the set, bank, row and aligned burst column. Each illegal command yields a one-cycle error pulse and no access.

In two-select organization the device holds two independent sets of eight banks. Set 0 is chosen by `cs0_n` and set 1 by `cs1_n`. Rows are 12 bits wide, giving 4096 rows. In one-select organization there is a single set of eight banks. Rows are 13 bits wide, giving 8192 rows, and the top row bit comes from the `row_msb` input. The organization strap `mode_one` and the burst-length strap `bl8` are static and may change only while reset is held.

Each bank FSM has three states: BK_IDLE (no open row), BK_ACTIVE (row open) and BK_CLOSING (row open, auto-precharge countdown running). Its transitions are:
- OPEN: BK_IDLE to BK_ACTIVE on an accepted activate.
- ARM: BK_ACTIVE to BK_CLOSING on an accepted read or write with the option bit set.
- EXTEND: BK_CLOSING to BK_CLOSING, with the countdown reloaded, on any accepted read or write.
- EXPIRE: BK_CLOSING to BK_IDLE when the countdown ends.
- SHUT: BK_ACTIVE or BK_CLOSING to BK_IDLE on a precharge that hits the bank.

Top module: `dual_org_cmd_decoder`

## Requirements
- R1: Commands are taken only at rising clock edges from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh. Codes 111, 000 and 110 do nothing. Every output is registered, so it reflects the command sampled at the previous rising edge.
- R2: In two-select mode (`mode_one`=0), `cs0_n` low alone selects set 0 and `cs1_n` low alone selects set 1. Both high means no command. Both low raises `cmd_err` and changes nothing.
- R3: In one-select mode (`mode_one`=1), `cs0_n` low selects set 0 and `cs1_n` is ignored. In this mode the activate row bit 12 is `row_msb`. In two-select mode `row_msb` is ignored and row bit 12 is 0. `core_set` is 0 for every strobe in one-select mode.
- R4: An activate to a BK_IDLE bank opens it with row {row bit 12, addr[11:0]}. It pulses `core_act` with `core_set`, `core_bank` and `core_row` set to that set, bank and row.
- R5: An activate to a bank in BK_ACTIVE or BK_CLOSING raises `cmd_err`, gives no strobe and leaves that bank's row and state unchanged.
- R6: A read or write to an open bank pulses `core_rd` or `core_wr`. The strobe carries the bank's stored open row and the column addr[8:0] with bits 1:0 forced to 0.
- R7: A read or write to a BK_IDLE bank raises `cmd_err` and gives no strobe.
- R8: A read or write whose addr[11:9] is non-zero raises `cmd_err`, gives no strobe and changes no bank state.
- R9: A read or write accepted at edge k with `opt`=1 on a BK_ACTIVE bank arms auto-precharge. The bank is still open for commands at edges k+1 to k+BL/2-1 and is closed at edge k+BL/2. Any read or write accepted while the bank is closing restarts this window from its own edge.
- R10: `bl8`=1 selects burst length 8 (close window of 4 cycles); `bl8`=0 selects burst length 4 (close window of 2 cycles).
- R11: A precharge with `opt`=0 closes the addressed bank, including a closing bank. A precharge of a closed bank is neither an error nor a change. A precharge with `opt`=1 closes all eight banks of the selected set and leaves the other set alone.
- R12: A refresh pulses `core_ref` with `core_set` only when all eight banks of the selected set are BK_IDLE. Otherwise it raises `cmd_err`.
- R13: Reset leaves every bank BK_IDLE and all outputs 0. In any cycle without a strobe, `core_set`, `core_bank`, `core_row` and `core_col` are 0. Never more than one of the four strobes and `cmd_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_one | input | 1 | Organization strap: 1 one-select, 0 two-select |
| bl8 | input | 1 | Burst-length strap: 1 for 8, 0 for 4 |
| cs0_n | input | 1 | Select for set 0, active low |
| cs1_n | input | 1 | Select for set 1 in two-select mode, active low |
| ras_n | input | 1 | Command strobe, row |
| cas_n | input | 1 | Command strobe, column |
| we_n | input | 1 | Command strobe, write |
| opt | input | 1 | Auto-precharge for read/write; all-banks for precharge |
| ba | input | 3 | Bank address |
| addr | input | 12 | Row address on activate, column address on read/write |
| row_msb | input | 1 | Row bit 12 in one-select mode |
| core_act | output | 1 | Row-open strobe |
| core_rd | output | 1 | Read access strobe |
| core_wr | output | 1 | Write access strobe |
| core_ref | output | 1 | Refresh strobe |
| core_set | output | 1 | Bank set of the strobe |
| core_bank | output | 3 | Bank of the access or activate |
| core_row | output | 13 | Row of the access or activate |
| core_col | output | 9 | Aligned burst start column |
| cmd_err | output | 1 | Illegal-command pulse |

## Verification
The assertions assume that `mode_one` and `bl8` move only while reset is asserted. Per-bank checks also take for granted that the top only steers an activate to a closed bank and an access to an open one. The stimulus sets both straps inside each reset phase and holds them steady while commands run. The commands are drawn at random over all codes, both chip selects, a narrowed bank range (to force collisions) and occasional out-of-range columns. A reference model in the bench, built from the requirements, predicts every registered output cycle by cycle.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_REF
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_CLOSING
    } bank_st_e;

endpackage

// File: rtl/dcd_cmd_decode.sv
module dcd_cmd_decode
    import dcd_pkg::*;
(
    input  logic mode_one,
    input  logic cs0_n,
    input  logic cs1_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output op_e  op,
    output logic sel_vld,
    output logic sel_set,
    output logic cs_err
);

    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b011:  op = OP_ACT;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            3'b010:  op = OP_PRE;
            3'b001:  op = OP_REF;
            default: op = OP_NOP;
        endcase
    end

    always_comb begin
        sel_vld = 1'b0;
        sel_set = 1'b0;
        cs_err  = 1'b0;
        if (mode_one) begin
            sel_vld = !cs0_n;
        end else begin
            unique case ({cs0_n, cs1_n})
                2'b01:   sel_vld = 1'b1;
                2'b10: begin
                    sel_vld = 1'b1;
                    sel_set = 1'b1;
                end
                2'b00:   cs_err = 1'b1;
                default: sel_vld = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dcd_bank_fsm.sv
module dcd_bank_fsm
    import dcd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_act,
    input  logic             ev_acc,
    input  logic             ev_ap,
    input  logic             ev_pre,
    input  logic [ROW_W-1:0] act_row,
    input  logic [CNT_W-1:0] close_len,
    output bank_st_e         st,
    output logic [ROW_W-1:0] row
);

    bank_st_e         st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [ROW_W-1:0] row_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
            row <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            row <= row_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        row_nxt = row;
        unique case (st)
            BK_IDLE: begin
                if (ev_act) begin
                    st_nxt  = BK_ACTIVE;
                    row_nxt = act_row;
                end
            end
            BK_ACTIVE: begin
                if (ev_pre) begin
                    st_nxt = BK_IDLE;
                end else if (ev_acc && ev_ap) begin
                    st_nxt  = BK_CLOSING;
                    cnt_nxt = close_len;
                end
            end
            BK_CLOSING: begin
                if (ev_pre) begin
                    st_nxt = BK_IDLE;
                end else if (ev_acc) begin
                    cnt_nxt = close_len;
                end else if (cnt == CNT_W'(1)) begin
                    st_nxt = BK_IDLE;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            default: st_nxt = BK_IDLE;
        endcase
    end

    AST_ACT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |-> st == BK_IDLE);                                     // R5
    AST_ACC_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_acc |-> st != BK_IDLE);                                     // R7
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != BK_IDLE) |=> (st == BK_IDLE || $stable(row)));          // R5
    AST_CLOSE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_CLOSING && cnt == CNT_W'(1) && !ev_acc) |=> st == BK_IDLE); // R9

endmodule

// File: rtl/dual_org_cmd_decoder.sv
module dual_org_cmd_decoder
    import dcd_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 12,
    parameter int COL_W     = 9,
    parameter int ALIGN_W   = 2,
    parameter int BL_SHORT  = 4,
    parameter int BL_LONG   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_one,
    input  logic                         bl8,
    input  logic                         cs0_n,
    input  logic                         cs1_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic                         opt,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         row_msb,
    output logic                         core_act,
    output logic                         core_rd,
    output logic                         core_wr,
    output logic                         core_ref,
    output logic                         core_set,
    output logic [$clog2(NUM_BANKS)-1:0] core_bank,
    output logic [ADDR_W:0]              core_row,
    output logic [COL_W-1:0]             core_col,
    output logic                         cmd_err
);

    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int ROW_W = ADDR_W + 1;
    localparam int NBK   = 2 * NUM_BANKS;
    localparam int IDX_W = BA_W + 1;
    localparam int CNT_W = $clog2(BL_LONG / 2);
    localparam logic [COL_W-1:0] COL_KEEP = ~COL_W'((1 << ALIGN_W) - 1);

    op_e              op;
    logic             sel_vld, sel_set, cs_err;
    bank_st_e         bk_st  [NBK];
    logic [ROW_W-1:0] bk_row [NBK];
    logic [1:0]       set_idle;
    logic [IDX_W-1:0] idx;
    logic [ROW_W-1:0] act_row;
    logic [CNT_W-1:0] close_len;
    logic             col_ok, acc_req, act_ok, acc_ok, ref_ok;
    logic             pre_one, pre_all, err_now;

    dcd_cmd_decode u_dec (
        .mode_one (mode_one),
        .cs0_n    (cs0_n),
        .cs1_n    (cs1_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .op       (op),
        .sel_vld  (sel_vld),
        .sel_set  (sel_set),
        .cs_err   (cs_err)
    );

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            set_idle[s] = 1'b1;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bk_st[s * NUM_BANKS + b] != BK_IDLE) set_idle[s] = 1'b0;
            end
        end
    end

    assign idx       = {sel_set, ba};
    assign act_row   = {mode_one & row_msb, addr};
    assign close_len = bl8 ? CNT_W'(BL_LONG / 2 - 1) : CNT_W'(BL_SHORT / 2 - 1);
    assign col_ok    = (addr[ADDR_W-1:COL_W] == '0);
    assign acc_req   = sel_vld && (op == OP_RD || op == OP_WR);
    assign act_ok    = sel_vld && op == OP_ACT && bk_st[idx] == BK_IDLE;
    assign acc_ok    = acc_req && bk_st[idx] != BK_IDLE && col_ok;
    assign ref_ok    = sel_vld && op == OP_REF && set_idle[sel_set];
    assign pre_one   = sel_vld && op == OP_PRE && !opt;
    assign pre_all   = sel_vld && op == OP_PRE && opt;
    assign err_now   = cs_err
                     || (sel_vld && op == OP_ACT && !act_ok)
                     || (acc_req && !acc_ok)
                     || (sel_vld && op == OP_REF && !set_idle[sel_set]);

    for (genvar g = 0; g < NBK; g++) begin : g_bank
        localparam logic G_SET = (g >= NUM_BANKS);
        logic hit, in_set;
        assign hit    = (idx == IDX_W'(g));
        assign in_set = (sel_set == G_SET);

        dcd_bank_fsm #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_act    (act_ok && hit),
            .ev_acc    (acc_ok && hit),
            .ev_ap     (opt),
            .ev_pre    ((pre_one && hit) || (pre_all && in_set)),
            .act_row   (act_row),
            .close_len (close_len),
            .st        (bk_st[g]),
            .row       (bk_row[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_act  <= 1'b0;
            core_rd   <= 1'b0;
            core_wr   <= 1'b0;
            core_ref  <= 1'b0;
            core_set  <= 1'b0;
            core_bank <= '0;
            core_row  <= '0;
            core_col  <= '0;
            cmd_err   <= 1'b0;
        end else begin
            core_act  <= act_ok;
            core_rd   <= acc_ok && op == OP_RD;
            core_wr   <= acc_ok && op == OP_WR;
            core_ref  <= ref_ok;
            core_set  <= (act_ok || acc_ok || ref_ok) ? sel_set : 1'b0;
            core_bank <= (act_ok || acc_ok) ? ba : '0;
            core_row  <= act_ok ? act_row : (acc_ok ? bk_row[idx] : '0);
            core_col  <= acc_ok ? (addr[COL_W-1:0] & COL_KEEP) : '0;
            cmd_err   <= err_now;
        end
    end

    AST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd || core_wr) |-> core_col[ALIGN_W-1:0] == '0);         // R6
    AST_ONESEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_one && (core_act || core_rd || core_wr || core_ref)) |-> !core_set); // R3
    AST_TWOSEL_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_one && core_act) |-> !core_row[ROW_W-1]);                // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_act, core_rd, core_wr, core_ref, cmd_err}));     // R13
    AST_REF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        core_ref |-> set_idle[core_set]);                               // R12

endmodule

// File: tb/sim_dual_org_cmd_decoder.sv
module sim_dual_org_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_one = 1'b0, bl8 = 1'b0;
    logic        cs0_n = 1'b1, cs1_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        opt = 1'b0, row_msb = 1'b0;
    logic [2:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        core_act, core_rd, core_wr, core_ref, core_set, cmd_err;
    logic [2:0]  core_bank;
    logic [12:0] core_row;
    logic [8:0]  core_col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int mst  [16];
    int mrow [16];
    int mcnt [16];

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100;
    localparam logic [2:0] C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

    always #5 clk = ~clk;

    dual_org_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .mode_one(mode_one), .bl8(bl8),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .opt(opt), .ba(ba), .addr(addr), .row_msb(row_msb),
        .core_act(core_act), .core_rd(core_rd), .core_wr(core_wr), .core_ref(core_ref),
        .core_set(core_set), .core_bank(core_bank), .core_row(core_row),
        .core_col(core_col), .cmd_err(cmd_err)
    );

    function automatic logic [30:0] outs();
        return {core_act, core_rd, core_wr, core_ref, core_set, core_bank,
                core_row, core_col, cmd_err};
    endfunction

    task automatic check(input string tag, input logic [30:0] got, input logic [30:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic m1, input logic b8);
        @(negedge clk);
        rst_n = 1'b0; mode_one = m1; bl8 = b8;
        cs0_n = 1'b1; cs1_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 16; j++) begin
            mst[j] = 0; mrow[j] = 0; mcnt[j] = 0;
        end
        #1 check("R13 reset state", outs(), '0);
    endtask

    task automatic issue(input string tag, input logic c0, input logic c1,
                         input logic [2:0] code, input logic o, input logic [2:0] b,
                         input logic [11:0] a, input logic msb);
        bit vld, set, cserr, isrd, iswr, acc, all_idle;
        bit e_act, e_rd, e_wr, e_ref, e_err;
        int i, len, r;
        logic [12:0] e_row;
        logic [8:0]  e_col;
        @(negedge clk);
        cs0_n = c0; cs1_n = c1; {ras_n, cas_n, we_n} = code;
        opt = o; ba = b; addr = a; row_msb = msb;
        vld = 0; set = 0; cserr = 0;
        if (mode_one) vld = !c0;
        else if (!c0 && c1) vld = 1;
        else if (c0 && !c1) begin vld = 1; set = 1; end
        else if (!c0 && !c1) cserr = 1;
        i = set * 8 + b;
        len = bl8 ? 3 : 1;
        r = {(mode_one & msb), a};
        all_idle = 1;
        for (int j = 0; j < 8; j++) if (mst[set * 8 + j] != 0) all_idle = 0;
        isrd = vld && code == C_RD;
        iswr = vld && code == C_WR;
        acc  = (isrd || iswr) && mst[i] != 0 && a[11:9] == 0;
        e_act = vld && code == C_ACT && mst[i] == 0;
        e_rd  = acc && isrd;
        e_wr  = acc && iswr;
        e_ref = vld && code == C_REF && all_idle;
        e_err = cserr || (vld && code == C_ACT && !e_act)
              || ((isrd || iswr) && !acc) || (vld && code == C_REF && !all_idle);
        e_row = e_act ? 13'(r) : (acc ? 13'(mrow[i]) : 13'd0);
        e_col = acc ? {a[8:2], 2'b00} : 9'd0;
        for (int j = 0; j < 16; j++) begin
            bit hitj, prej;
            hitj = (j == i);
            prej = vld && code == C_PRE && ((o && (j / 8) == set) || (!o && hitj));
            if (prej) mst[j] = 0;
            else if (e_act && hitj) begin mst[j] = 1; mrow[j] = r; end
            else if (acc && hitj) begin
                if (mst[j] == 1 && o) begin mst[j] = 2; mcnt[j] = len; end
                else if (mst[j] == 2) mcnt[j] = len;
            end else if (mst[j] == 2) begin
                if (mcnt[j] == 1) mst[j] = 0; else mcnt[j]--;
            end
        end
        @(posedge clk);
        #1 check(tag, outs(), {e_act, e_rd, e_wr, e_ref,
                               (e_act || acc || e_ref) ? set : 1'b0,
                               (e_act || acc) ? b : 3'd0, e_row, e_col, e_err});
    endtask

    task automatic nop(input string tag);
        issue(tag, 1, 1, C_NOP, 0, 0, 0, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // two-select organization, burst length 4
        do_reset(0, 0);
        issue("R4 activate opens bank", 0, 1, C_ACT, 0, 3, 12'hABC, 0);
        issue("R5 activate on open bank", 0, 1, C_ACT, 0, 3, 12'h111, 0);
        issue("R6 read aligned column", 0, 1, C_RD, 0, 3, 12'h1FF, 0);
        issue("R7 read on closed bank", 0, 1, C_RD, 0, 5, 12'h010, 0);
        issue("R8 column out of range", 0, 1, C_WR, 0, 3, 12'h200, 0);
        issue("R2 set1 activate, R3 msb ignored", 1, 0, C_ACT, 0, 3, 12'h123, 1);
        issue("R2 both selects low", 0, 0, C_ACT, 0, 6, 12'h000, 0);
        issue("R12 refresh with open bank", 0, 1, C_REF, 0, 0, 0, 0);
        issue("R9 write with auto-precharge", 0, 1, C_WR, 1, 3, 12'h044, 0);
        nop("R9 countdown");
        issue("R9 bank closed after window", 0, 1, C_RD, 0, 3, 12'h044, 0);
        issue("R9 reopen", 0, 1, C_ACT, 0, 3, 12'h0F0, 0);
        issue("R9 arm again", 0, 1, C_WR, 1, 3, 12'h008, 0);
        issue("R9 open inside window, restarts", 0, 1, C_RD, 0, 3, 12'h00C, 0);
        nop("R9 countdown");
        issue("R9 closed after restarted window", 0, 1, C_RD, 0, 3, 12'h00C, 0);
        issue("R11 precharge one bank", 1, 0, C_PRE, 0, 3, 0, 0);
        issue("R11 precharged bank is closed", 1, 0, C_RD, 0, 3, 0, 0);
        issue("R11 precharge closed bank", 1, 0, C_PRE, 0, 3, 0, 0);
        issue("R11 open set0 bank0", 0, 1, C_ACT, 0, 0, 12'h001, 0);
        issue("R11 open set1 bank1", 1, 0, C_ACT, 0, 1, 12'h002, 0);
        issue("R11 precharge all set0", 0, 1, C_PRE, 1, 5, 0, 0);
        issue("R12 refresh set0 all closed", 0, 1, C_REF, 0, 0, 0, 0);
        issue("R11 set1 untouched", 1, 0, C_RD, 0, 1, 12'h020, 0);
        issue("R12 refresh set1 busy", 1, 0, C_REF, 0, 0, 0, 0);
        issue("R1 code 000 ignored", 0, 1, 3'b000, 0, 2, 12'h0, 0);
        issue("R1 code 110 ignored", 0, 1, 3'b110, 0, 2, 12'h0, 0);
        for (int n = 0; n < 600; n++) begin
            int w, k;
            logic [2:0] c;
            logic s0, s1;
            w = $urandom % 100;
            c = (w < 25) ? C_ACT : (w < 45) ? C_RD : (w < 65) ? C_WR :
                (w < 80) ? C_PRE : (w < 85) ? C_REF : (w < 95) ? C_NOP : 3'b000;
            k = $urandom % 100;
            s0 = !(k < 45 || k >= 95); s1 = !(k >= 45 && k < 90) && !(k >= 95);
            if (k >= 90 && k < 95) begin s0 = 1; s1 = 1; end
            issue("R1 random two-select", s0, s1, c, ($urandom % 10) < 3,
                  3'(($urandom % 10) < 8 ? $urandom % 4 : $urandom % 8),
                  12'(($urandom % 10) < 9 ? $urandom % 512 : $urandom),
                  1'($urandom));
        end
        // one-select organization, burst length 8
        do_reset(1, 1);
        issue("R3 one-select row msb", 0, 1, C_ACT, 0, 2, 12'h005, 1);
        issue("R3 cs1 ignored alone", 1, 0, C_ACT, 0, 4, 12'h006, 0);
        issue("R3 cs1 ignored with cs0", 0, 0, C_ACT, 0, 4, 12'h007, 0);
        issue("R10 arm burst 8", 0, 1, C_RD, 1, 2, 12'h013, 0);
        nop("R10 countdown");
        nop("R10 countdown");
        issue("R10 still open at k+3", 0, 1, C_WR, 0, 2, 12'h020, 0);
        nop("R10 countdown");
        nop("R10 countdown");
        nop("R10 countdown");
        issue("R10 closed at restart+4", 0, 1, C_RD, 0, 2, 12'h020, 0);
        for (int n = 0; n < 600; n++) begin
            int w;
            logic [2:0] c;
            w = $urandom % 100;
            c = (w < 25) ? C_ACT : (w < 45) ? C_RD : (w < 65) ? C_WR :
                (w < 80) ? C_PRE : (w < 85) ? C_REF : (w < 95) ? C_NOP : 3'b110;
            issue("R1 random one-select", ($urandom % 10) < 1, 1'($urandom), c,
                  ($urandom % 10) < 3, 3'($urandom % 4),
                  12'(($urandom % 10) < 9 ? $urandom % 512 : $urandom),
                  1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule